// File: doc/BRIEF.md
# Counter array timer

This block is a 16-bit up-counter shared by five capture/compare units. It steps on a count pulse taken from one of four sources: the system clock divided by 12 or by 6, an overflow pulse from a neighbouring timer, or rising edges of an external pin. A run bit starts and stops it. When it wraps from 0xFFFF to 0x0000 it sets a wrap flag.

Each unit has one 16-bit register that serves two roles. In capture mode, a selected edge on the unit's input pin copies the counter into that register. In compare mode, the counter stepping onto the register's value raises the unit's flag. Software reads and writes the block through a byte-wide register bus. Status flags are set by hardware or by a set strobe and are cleared only by a clear strobe. A single interrupt line combines every flag with its enable.

Top module: `cat_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o` is 0.
- R2: The control register at address 0 reads {wrap flag (bit 7), run (bit 6), 0 (bit 5), unit flags 4..0 (bits 4..0)}. A write to it changes only the run bit, from `wdata_i[6]`. Bit 5 always reads 0, and writes never change any flag.
- R3: While run is 0, the counter holds its value. While run is 1, it advances by exactly one on each count pulse. A bus write to a counter byte takes priority over a count step.
- R4: The general mode register at address 1 holds the source code in bits 2:1 and the wrap interrupt enable in bit 0; its other bits read 0. Source code 0 produces one count pulse every 12 clocks, and code 1 produces one every 6 clocks.
- R5: Source code 2 counts each clock cycle in which `tmr0_ovf_i` is 1. Source code 3 counts each rising edge of `ext_cnt_i` after a two-flop synchronizer. The pin may toggle at no more than a quarter of the clock rate.
- R6: A count step from 0xFFFF leaves the counter at 0x0000 and sets the wrap flag.
- R7: Unit n's mode register is at address 2+n: bit 6 compare enable, bit 5 rising capture, bit 4 falling capture, bit 3 match flag enable, bit 0 flag interrupt enable; the other bits read 0. A synchronized edge of `cap_i[n]` whose capture bit is set copies the counter into the unit register and sets flag n. An edge whose capture bit is clear changes neither.
- R8: When compare enable and match enable are both 1, a count step that makes the counter equal to unit n's register sets flag n. With match enable 0, no flag is set.
- R9: `flag_set_i` and `flag_clr_i` use bit 5 for the wrap flag and bit n for unit flag n. A flag is cleared only by its clear bit. A hardware set or set strobe in the same cycle as a clear leaves the flag at 1.
- R10: `irq_o` is 1 exactly when the wrap flag and its enable are both 1, or when some unit flag and that unit's bit 0 are both 1.
- R11: The counter reads and writes at addresses 7 (low byte) and 8 (high byte). Unit n's register is at addresses 9+2n (low byte) and 10+2n (high byte). Reads are combinational from `addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 5 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| flag_set_i | input | 6 | Per-flag software set strobes |
| flag_clr_i | input | 6 | Per-flag software clear strobes |
| tmr0_ovf_i | input | 1 | Overflow pulse from the neighbouring timer |
| ext_cnt_i | input | 1 | External count pin |
| cap_i | input | 5 | Capture input pins, one per unit |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The properties assume that `tmr0_ovf_i` is a clean pulse synchronous to the clock, and that `ext_cnt_i` and `cap_i` stay at each level for several clocks, so that each transition produces one synchronized edge. The stimulus holds the external pin high and low for four clocks each, and holds each capture level for at least five clocks. It drives the overflow input for exactly one cycle per pulse. All inputs change on the falling clock edge, and counts are measured over windows that are a whole number of prescaler periods long.

// File: rtl/cat_pkg.sv
package cat_pkg;

    localparam int MAX_UNITS   = 5;
    localparam int ADDR_W      = 5;
    localparam int A_CTRL      = 0;
    localparam int A_GMODE     = 1;
    localparam int A_UMODE0    = 2;
    localparam int A_CNT_LO    = 7;
    localparam int A_CNT_HI    = 8;
    localparam int A_UREG0     = 9;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_FAST = 2'd1,
        SRC_TMR0 = 2'd2,
        SRC_PIN  = 2'd3
    } src_e;

    typedef struct packed {
        logic cmp_en;
        logic cap_rise;
        logic cap_fall;
        logic match_en;
        logic irq_en;
    } unit_mode_t;

    function automatic unit_mode_t to_mode(logic [7:0] b);
        unit_mode_t m;
        m.cmp_en   = b[6];
        m.cap_rise = b[5];
        m.cap_fall = b[4];
        m.match_en = b[3];
        m.irq_en   = b[0];
        return m;
    endfunction

    function automatic logic [7:0] from_mode(unit_mode_t m);
        return {1'b0, m.cmp_en, m.cap_rise, m.cap_fall, m.match_en, 2'b00, m.irq_en};
    endfunction

endpackage

// File: rtl/cat_sync.sv
module cat_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] dly_o
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl_o = s2_q;
    assign dly_o = s3_q;
endmodule

// File: rtl/cat_prescale.sv
module cat_prescale
    import cat_pkg::*;
#(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 6
) (
    input  logic clk_i,
    input  logic rst_i,
    input  src_e src_i,
    input  logic tmr0_i,
    input  logic pin_rise_i,
    output logic tick_o
);
    localparam int PS_W = $clog2(SLOW_DIV);

    logic [PS_W-1:0] ps_q;
    logic            slow_tick, fast_tick;

    always_ff @(posedge clk_i) begin
        if (rst_i)                             ps_q <= '0;
        else if (ps_q == PS_W'(SLOW_DIV - 1))  ps_q <= '0;
        else                                   ps_q <= ps_q + 1'b1;
    end

    assign slow_tick = (ps_q == PS_W'(SLOW_DIV - 1));
    assign fast_tick = ((int'(ps_q) % FAST_DIV) == FAST_DIV - 1);

    always_comb begin
        unique case (src_i)
            SRC_SLOW: tick_o = slow_tick;
            SRC_FAST: tick_o = fast_tick;
            SRC_TMR0: tick_o = tmr0_i;
            default:  tick_o = pin_rise_i;
        endcase
    end
endmodule

// File: rtl/cat_unit.sv
module cat_unit
    import cat_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  unit_mode_t       mode_i,
    input  logic [CNT_W-1:0] cnt_q_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic             step_i,
    input  logic             pin_lvl_i,
    input  logic             pin_dly_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [7:0]       wdata_i,
    output logic [CNT_W-1:0] reg_o,
    output logic             evt_o
);
    logic [CNT_W-1:0] reg_q;
    logic             cap_hit, match_hit;

    assign cap_hit   = (mode_i.cap_rise & pin_lvl_i & ~pin_dly_i)
                     | (mode_i.cap_fall & ~pin_lvl_i & pin_dly_i);
    assign match_hit = mode_i.cmp_en & mode_i.match_en & step_i & (cnt_nxt_i == reg_q);

    always_ff @(posedge clk_i) begin
        if (rst_i)        reg_q <= '0;
        else if (cap_hit) reg_q <= cnt_q_i;
        else if (wr_lo_i) reg_q[7:0] <= wdata_i;
        else if (wr_hi_i) reg_q[CNT_W-1:8] <= wdata_i[CNT_W-9:0];
    end

    assign reg_o = reg_q;
    assign evt_o = cap_hit | match_hit;
endmodule

// File: rtl/cat_timer.sv
module cat_timer
    import cat_pkg::*;
#(
    parameter int NUM_UNITS = 5,
    parameter int CNT_W     = 16,
    parameter int SLOW_DIV  = 12,
    parameter int FAST_DIV  = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_i,
    input  logic [7:0]           wdata_i,
    output logic [7:0]           rdata_o,
    input  logic [NUM_UNITS:0]   flag_set_i,
    input  logic [NUM_UNITS:0]   flag_clr_i,
    input  logic                 tmr0_ovf_i,
    input  logic                 ext_cnt_i,
    input  logic [NUM_UNITS-1:0] cap_i,
    output logic                 irq_o
);
    localparam int WRAP_BIT = NUM_UNITS;

    logic                 run_q, ecf_q, cf_q;
    src_e                 src_q;
    logic [NUM_UNITS-1:0] ccf_q;
    unit_mode_t           umode_q [NUM_UNITS];
    logic [CNT_W-1:0]     cnt_q, cnt_nxt;
    logic                 we_ctrl, we_gmode, we_lo, we_hi;
    logic                 tick, step, cf_hw;
    logic                 pin_lvl, pin_dly;
    logic [NUM_UNITS-1:0] cap_lvl, cap_dly, unit_evt;
    logic [CNT_W-1:0]     ureg [NUM_UNITS];

    assign we_ctrl  = wr_i && (int'(addr_i) == A_CTRL);
    assign we_gmode = wr_i && (int'(addr_i) == A_GMODE);
    assign we_lo    = wr_i && (int'(addr_i) == A_CNT_LO);
    assign we_hi    = wr_i && (int'(addr_i) == A_CNT_HI);

    cat_sync #(.W(1)) pin_sync_i (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(ext_cnt_i), .lvl_o(pin_lvl), .dly_o(pin_dly)
    );

    cat_sync #(.W(NUM_UNITS)) cap_sync_i (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(cap_i), .lvl_o(cap_lvl), .dly_o(cap_dly)
    );

    cat_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) pre_i (
        .clk_i(clk_i), .rst_i(rst_i), .src_i(src_q), .tmr0_i(tmr0_ovf_i),
        .pin_rise_i(pin_lvl & ~pin_dly), .tick_o(tick)
    );

    assign step    = run_q & tick;
    assign cnt_nxt = cnt_q + 1'b1;
    assign cf_hw   = step & (cnt_q == '1) & ~we_lo & ~we_hi;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            ecf_q <= 1'b0;
            src_q <= SRC_SLOW;
            cf_q  <= 1'b0;
            ccf_q <= '0;
        end else begin
            if (we_lo)      cnt_q[7:0] <= wdata_i;
            else if (we_hi) cnt_q[CNT_W-1:8] <= wdata_i[CNT_W-9:0];
            else if (step)  cnt_q <= cnt_nxt;
            if (we_ctrl)  run_q <= wdata_i[6];
            if (we_gmode) begin
                src_q <= src_e'(wdata_i[2:1]);
                ecf_q <= wdata_i[0];
            end
            cf_q  <= cf_hw | flag_set_i[WRAP_BIT] | (cf_q & ~flag_clr_i[WRAP_BIT]);
            ccf_q <= unit_evt | flag_set_i[NUM_UNITS-1:0] | (ccf_q & ~flag_clr_i[NUM_UNITS-1:0]);
        end
    end

    for (genvar n = 0; n < NUM_UNITS; n++) begin : g_unit
        logic we_mode;
        assign we_mode = wr_i && (int'(addr_i) == A_UMODE0 + n);

        always_ff @(posedge clk_i) begin
            if (rst_i)        umode_q[n] <= '0;
            else if (we_mode) umode_q[n] <= to_mode(wdata_i);
        end

        cat_unit #(.CNT_W(CNT_W)) unit_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .mode_i    (umode_q[n]),
            .cnt_q_i   (cnt_q),
            .cnt_nxt_i (cnt_nxt),
            .step_i    (step),
            .pin_lvl_i (cap_lvl[n]),
            .pin_dly_i (cap_dly[n]),
            .wr_lo_i   (wr_i && (int'(addr_i) == A_UREG0 + 2*n)),
            .wr_hi_i   (wr_i && (int'(addr_i) == A_UREG0 + 2*n + 1)),
            .wdata_i   (wdata_i),
            .reg_o     (ureg[n]),
            .evt_o     (unit_evt[n])
        );
    end

    always_comb begin
        logic [MAX_UNITS-1:0] ccf_b;
        logic                 unit_irq;
        ccf_b    = '0;
        unit_irq = 1'b0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            ccf_b[i] = ccf_q[i];
            unit_irq = unit_irq | (ccf_q[i] & umode_q[i].irq_en);
        end
        irq_o = (cf_q & ecf_q) | unit_irq;

        rdata_o = '0;
        case (int'(addr_i))
            A_CTRL:   rdata_o = {cf_q, run_q, 1'b0, ccf_b};
            A_GMODE:  rdata_o = {5'b0, src_q, ecf_q};
            A_CNT_LO: rdata_o = cnt_q[7:0];
            A_CNT_HI: rdata_o = cnt_q[CNT_W-1:8];
            default:  rdata_o = '0;
        endcase
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (int'(addr_i) == A_UMODE0 + i)      rdata_o = from_mode(umode_q[i]);
            if (int'(addr_i) == A_UREG0 + 2*i)     rdata_o = ureg[i][7:0];
            if (int'(addr_i) == A_UREG0 + 2*i + 1) rdata_o = ureg[i][CNT_W-1:8];
        end
    end
endmodule

module cat_timer_chk
    import cat_pkg::*;
#(
    parameter int NUM_UNITS = 5,
    parameter int CNT_W     = 16
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 wr_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [NUM_UNITS:0]   flag_clr_i,
    input logic                 irq_o,
    input logic [CNT_W-1:0]     cnt_q,
    input logic                 run_q,
    input logic                 cf_q,
    input logic [NUM_UNITS-1:0] ccf_q,
    input logic                 cf_hw
);
    logic cnt_wr;
    assign cnt_wr = wr_i && ((int'(addr_i) == A_CNT_LO) || (int'(addr_i) == A_CNT_HI));

    // R3
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run_q && !cnt_wr) |=> $stable(cnt_q));

    // R3
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(cnt_wr) && (cnt_q != $past(cnt_q))) |-> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(cf_hw) |-> (cnt_q == '0));

    // R9
    cf_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(cf_q) |-> $past(flag_clr_i[NUM_UNITS]));

    // R9
    ccf_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (($past(ccf_q) & ~ccf_q & ~$past(flag_clr_i[NUM_UNITS-1:0])) == '0));

    // R9
    hw_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(cf_hw) |-> cf_q);

    // R10
    irq_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (cf_q || (ccf_q != '0)));
endmodule

bind cat_timer cat_timer_chk #(.NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W)) chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .wr_i(wr_i), .addr_i(addr_i),
    .flag_clr_i(flag_clr_i), .irq_o(irq_o), .cnt_q(cnt_q), .run_q(run_q),
    .cf_q(cf_q), .ccf_q(ccf_q), .cf_hw(cf_hw)
);

// File: tb/cat_timer_tb.sv
module cat_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [5:0] fset = '0;
    logic [5:0] fclr = '0;
    logic       tmr0 = 1'b0;
    logic       ext = 1'b0;
    logic [4:0] cap = '0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cat_timer dut_i (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_i(wr_en), .wdata_i(wdata),
        .rdata_o(rdata), .flag_set_i(fset), .flag_clr_i(fclr), .tmr0_ovf_i(tmr0),
        .ext_cnt_i(ext), .cap_i(cap), .irq_o(irq)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 5'(a); wdata = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        addr = 5'(a);
        #2;
        v = int'(rdata);
    endtask

    task automatic rd16(input int a, output int v);
        int lo, hi;
        rd(a, lo);
        rd(a + 1, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic set_cnt(input int v);
        wr(7, v & 8'hFF);
        wr(8, (v >> 8) & 8'hFF);
    endtask

    task automatic strobe(input logic [5:0] s, input logic [5:0] c);
        @(negedge clk);
        fset = s; fclr = c;
        @(negedge clk);
        fset = '0; fclr = '0;
    endtask

    task automatic tmr_pulses(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); tmr0 = 1'b1;
            @(negedge clk); tmr0 = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 19; a++) begin
            rd(a, v);
            chk($sformatf("R1 reset reg %0d", a), v, 0);
        end
        chk("R1 reset irq", int'(irq), 0);
    endtask

    task automatic t_regmap();
        int v;
        wr(0, 8'hFF);
        rd(0, v);
        chk("R2 ctrl write only run, bit5 zero", v, 8'h40);
        wr(0, 8'h00);
        wr(1, 8'hFF);
        rd(1, v);
        chk("R4 general mode fields", v, 8'h07);
        wr(1, 8'h00);
        wr(4, 8'hFF);
        rd(4, v);
        chk("R7 unit mode fields", v, 8'h79);
        wr(4, 8'h00);
        wr(13, 8'hCD); wr(14, 8'hAB);
        rd16(13, v);
        chk("R11 unit 2 register map", v, 16'hABCD);
        set_cnt(16'h1357);
        rd16(7, v);
        chk("R11 counter map", v, 16'h1357);
    endtask

    task automatic t_prescale();
        int v;
        set_cnt(0);
        repeat (50) @(negedge clk);
        rd16(7, v);
        chk("R3 stopped counter holds", v, 0);
        wr(1, 8'h00);
        wr(0, 8'h40);
        repeat (118) @(negedge clk);
        wr(0, 8'h00);
        rd16(7, v);
        chk("R4 slow divide over 120 clocks", v, 10);
        set_cnt(0);
        wr(1, 8'h02);
        wr(0, 8'h40);
        repeat (118) @(negedge clk);
        wr(0, 8'h00);
        rd16(7, v);
        chk("R4 fast divide over 120 clocks", v, 20);
    endtask

    task automatic t_sources();
        int v;
        set_cnt(0);
        wr(1, 8'h04);
        wr(0, 8'h40);
        tmr_pulses(9);
        wr(0, 8'h00);
        rd16(7, v);
        chk("R5 timer0 pulses counted", v, 9);
        tmr_pulses(3);
        rd16(7, v);
        chk("R3 pulses ignored while stopped", v, 9);
        set_cnt(0);
        wr(1, 8'h06);
        wr(0, 8'h40);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); ext = 1'b1;
            repeat (4) @(negedge clk); ext = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(0, 8'h00);
        rd16(7, v);
        chk("R5 external pin rising edges", v, 7);
    endtask

    task automatic t_wrap();
        int v;
        set_cnt(16'hFFFE);
        wr(1, 8'h04);
        wr(0, 8'h40);
        tmr_pulses(2);
        wr(0, 8'h00);
        rd16(7, v);
        chk("R6 counter wraps to zero", v, 0);
        rd(0, v);
        chk("R6 wrap flag set", v, 8'h80);
        chk("R10 irq masked without enable", int'(irq), 0);
        wr(0, 8'h00);
        rd(0, v);
        chk("R2 ctrl write leaves flag", v, 8'h80);
        wr(1, 8'h05);
        #2;
        chk("R10 irq with wrap enable", int'(irq), 1);
        strobe(6'h00, 6'h20);
        #2;
        rd(0, v);
        chk("R9 clear strobe clears wrap flag", v, 8'h00);
        chk("R10 irq drops after clear", int'(irq), 0);
        wr(1, 8'h04);
    endtask

    task automatic t_priority();
        int v;
        set_cnt(16'hFFFF);
        strobe(6'h20, 6'h00);
        wr(0, 8'h40);
        @(negedge clk); tmr0 = 1'b1; fclr = 6'h20;
        @(negedge clk); tmr0 = 1'b0; fclr = 6'h00;
        wr(0, 8'h00);
        rd(0, v);
        chk("R9 hardware set beats same-cycle clear", v, 8'h80);
        rd16(7, v);
        chk("R6 wrap during clear", v, 0);
        strobe(6'h00, 6'h20);
        rd(0, v);
        chk("R9 flag cleared afterwards", v, 8'h00);
    endtask

    task automatic t_capture();
        int v;
        wr(3, 8'h20);
        set_cnt(16'h1234);
        @(negedge clk); cap[1] = 1'b1;
        repeat (5) @(negedge clk);
        rd16(11, v);
        chk("R7 rising capture value", v, 16'h1234);
        rd(0, v);
        chk("R7 rising capture flag", v, 8'h02);
        strobe(6'h00, 6'h02);
        set_cnt(16'h2222);
        @(negedge clk); cap[1] = 1'b0;
        repeat (5) @(negedge clk);
        rd16(11, v);
        chk("R7 falling edge ignored in rising mode", v, 16'h1234);
        rd(0, v);
        chk("R7 no flag from ignored edge", v, 8'h00);
        wr(5, 8'h10);
        set_cnt(16'h0ABC);
        @(negedge clk); cap[3] = 1'b1;
        repeat (5) @(negedge clk);
        rd(0, v);
        chk("R7 rising edge ignored in falling mode", v, 8'h00);
        @(negedge clk); cap[3] = 1'b0;
        repeat (5) @(negedge clk);
        rd16(15, v);
        chk("R7 falling capture value", v, 16'h0ABC);
        rd(0, v);
        chk("R7 falling capture flag", v, 8'h08);
        wr(6, 8'h30);
        set_cnt(16'h0101);
        @(negedge clk); cap[4] = 1'b1;
        repeat (5) @(negedge clk);
        rd16(17, v);
        chk("R7 both-edge mode, rising", v, 16'h0101);
        set_cnt(16'h0202);
        @(negedge clk); cap[4] = 1'b0;
        repeat (5) @(negedge clk);
        rd16(17, v);
        chk("R7 both-edge mode, falling", v, 16'h0202);
        strobe(6'h00, 6'h1F);
        for (int a = 2; a < 7; a++) wr(a, 8'h00);
        rd(0, v);
        chk("R9 unit flags cleared", v, 8'h00);
    endtask

    task automatic t_match();
        int v;
        wr(9, 8'h05); wr(10, 8'h00);
        wr(13, 8'h05); wr(14, 8'h00);
        wr(2, 8'h48);
        wr(4, 8'h40);
        set_cnt(0);
        wr(1, 8'h04);
        wr(0, 8'h40);
        tmr_pulses(4);
        rd(0, v);
        chk("R8 no match before equal", v, 8'h40);
        tmr_pulses(1);
        wr(0, 8'h00);
        rd(0, v);
        chk("R8 match sets unit 0 only", v, 8'h01);
        chk("R10 irq masked for unit", int'(irq), 0);
        wr(2, 8'h49);
        #2;
        chk("R10 irq from unit flag", int'(irq), 1);
        strobe(6'h00, 6'h01);
        #2;
        chk("R10 irq clears with flag", int'(irq), 0);
    endtask

    initial begin
        #4_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_prescale();
        t_sources();
        t_wrap();
        t_priority();
        t_capture();
        t_match();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule